// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent page translations so that most memory accesses can be turned into physical addresses without walking the page table. A requester presents a 32-bit virtual address with a lookup strobe. Every valid entry compares its stored virtual page number against the address in parallel. On a hit, the physical address comes back combinationally in the same cycle. On a miss, the block raises a miss flag and issues a walk request for that page.

A hardware table walker answers with either a translation or a fault. A translation is written into the buffer. A fault writes nothing and is forwarded straight to the requester. A privileged write port can install a translation directly or invalidate the whole buffer. Requests on that port made outside kernel mode have no effect and raise a protection flag.

When the buffer is full, the entry that was used least recently is replaced. An entry counts as used when a lookup hits it or when it is written.

Top module: `xlat_tlb`

## Requirements
- R1: When `lk_req` is high and a valid entry holds the page number `lk_vaddr[31:12]`, `lk_hit` is 1 in that same cycle and `lk_paddr` equals that entry's physical page number concatenated with `lk_vaddr[11:0]`.
- R2: When `lk_req` is high and no valid entry matches, `lk_miss` and `walk_req` are 1 in that cycle, `walk_vpn` equals `lk_vaddr[31:12]`, and `lk_hit` is 0. With `lk_req` low, `lk_hit`, `lk_miss` and `walk_req` are all 0.
- R3: A walker response with `wk_valid` high and `wk_fault` low writes the pair (`wk_vpn`, `wk_ppn`) at the clock edge. A lookup of that page in the next cycle hits.
- R4: A walker response with `wk_fault` high drives `lk_fault` high in the same cycle and writes no entry.
- R5: A new translation goes into an invalid entry whenever one exists. Filling as many distinct pages as there are entries, starting from an empty buffer, therefore evicts none of them.
- R6: When every entry is valid, a new page replaces the least recently used entry. Both a lookup hit and a write count as a use, and the order is updated at the edge that ends the hitting lookup.
- R7: A write, from either source, whose page number is already cached overwrites that entry in place instead of taking a new one.
- R8: With `kw_kernel` high, `kw_en` installs (`kw_vpn`, `kw_ppn`).
- R9: With `kw_kernel` low, `kw_en` and `kw_flush` leave the stored translations unchanged, and `prot_err` is 1 in the following cycle only.
- R10: With `kw_kernel` high, `kw_flush` invalidates every entry at one clock edge, so that all lookups in the next cycle miss.
- R11: When several updates fall in one cycle, a flush wins over a kernel write, and a kernel write wins over a walker fill. The losing update is dropped.
- R12: After reset, every entry is invalid and `prot_err` is 0.
- R13: At most one entry matches any page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found no translation |
| lk_paddr | output | 32 | Translated physical address, 0 when there is no hit |
| lk_fault | output | 1 | Walker reported a fault |
| walk_req | output | 1 | Request to the walker to resolve a page |
| walk_vpn | output | 20 | Page number to walk |
| wk_valid | input | 1 | Walker response strobe |
| wk_fault | input | 1 | Walker response is a fault |
| wk_vpn | input | 20 | Page number in the walker response |
| wk_ppn | input | 20 | Physical page number in the walker response |
| kw_kernel | input | 1 | Requester runs in kernel mode |
| kw_en | input | 1 | Direct translation write |
| kw_flush | input | 1 | Invalidate all entries |
| kw_vpn | input | 20 | Page number for a direct write |
| kw_ppn | input | 20 | Physical page number for a direct write |
| prot_err | output | 1 | Privileged request was refused |

## Verification
The bench builds the buffer with four entries instead of eight. With that depth, a full buffer, the eviction of the least recently used entry, and the way a hit reorders the victims can all be reached after a handful of fills. The page and offset widths keep their default values, so the address split and the concatenation are checked at full size.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_DEF_ENTRIES = 8;
  localparam int unsigned TLB_DEF_VA_W    = 32;
  localparam int unsigned TLB_DEF_PA_W    = 32;
  localparam int unsigned TLB_DEF_OFF_W   = 12;

  typedef enum logic [1:0] {
    WSRC_NONE   = 2'd0,
    WSRC_KERNEL = 2'd1,
    WSRC_WALK   = 2'd2,
    WSRC_FLUSH  = 2'd3
  } wsrc_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned N     = 8,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [N-1:0]            valid,
  input  logic [TAG_W-1:0]        key,
  output logic [N-1:0]            match,
  output logic                    any,
  output logic [IDX_W-1:0]        idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  logic [N-1:0][IDX_W-1:0] age_q, age_d;
  logic [IDX_W-1:0]        touched_age;

  assign touched_age = age_q[touch_idx];

  always_comb begin
    age_d = age_q;
    if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx) begin
          age_d[i] = '0;
        end else if (age_q[i] < touched_age) begin
          age_d[i] = age_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == IDX_W'(N - 1)) oldest_idx = IDX_W'(i);
    end
  end

  // Ages must stay a permutation, so the oldest entry is unique.
  logic [N-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < N; i++) age_seen[age_q[i]] = 1'b1;
  end

  a_r6_age_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    (&age_seen));

  a_r6_touched_youngest: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (age_q[$past(touch_idx)] == '0));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid,
  input  logic [IDX_W-1:0] oldest_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic             has_free;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim_idx = has_free ? free_idx : oldest_idx;
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = TLB_DEF_ENTRIES,
  parameter int unsigned VA_W    = TLB_DEF_VA_W,
  parameter int unsigned PA_W    = TLB_DEF_PA_W,
  parameter int unsigned OFF_W   = TLB_DEF_OFF_W,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PPN_W  = PA_W - OFF_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_fault,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             wk_valid,
  input  logic             wk_fault,
  input  logic [VPN_W-1:0] wk_vpn,
  input  logic [PPN_W-1:0] wk_ppn,
  input  logic             kw_kernel,
  input  logic             kw_en,
  input  logic             kw_flush,
  input  logic [VPN_W-1:0] kw_vpn,
  input  logic [PPN_W-1:0] kw_ppn,
  output logic             prot_err
);
  // Entry storage: valid bits are reset, tag and page fields are not.
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q, ppn_d;
  logic                          store_en;
  logic                          prot_q, prot_d;

  // Lookup path.
  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_match;
  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  tlb_cam #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_cam (
    .tags  (tag_q),
    .valid (valid_q),
    .key   (lk_vpn),
    .match (lk_match),
    .any   (lk_any),
    .idx   (lk_idx)
  );

  assign lk_hit   = lk_req && lk_any;
  assign lk_miss  = lk_req && !lk_any;
  assign lk_paddr = lk_hit ? {ppn_q[lk_idx], lk_vaddr[OFF_W-1:0]} : '0;
  assign walk_req = lk_miss;
  assign walk_vpn = lk_vpn;
  assign lk_fault = wk_valid && wk_fault;

  // Update arbitration: flush, then kernel write, then walker fill.
  wsrc_e            wsrc;
  logic             wr_en;
  logic [VPN_W-1:0] wr_vpn;
  logic [PPN_W-1:0] wr_ppn;

  always_comb begin
    wsrc = WSRC_NONE;
    if (kw_kernel && kw_flush)       wsrc = WSRC_FLUSH;
    else if (kw_kernel && kw_en)     wsrc = WSRC_KERNEL;
    else if (wk_valid && !wk_fault)  wsrc = WSRC_WALK;
  end

  assign wr_en  = (wsrc == WSRC_KERNEL) || (wsrc == WSRC_WALK);
  assign wr_vpn = (wsrc == WSRC_KERNEL) ? kw_vpn : wk_vpn;
  assign wr_ppn = (wsrc == WSRC_KERNEL) ? kw_ppn : wk_ppn;

  // Write target: an existing copy of the page, else the victim.
  logic [ENTRIES-1:0] wr_match;
  logic               wr_any;
  logic [IDX_W-1:0]   wr_match_idx;
  logic [IDX_W-1:0]   oldest_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   wr_idx;

  tlb_cam #(.N(ENTRIES), .TAG_W(VPN_W)) u_wr_cam (
    .tags  (tag_q),
    .valid (valid_q),
    .key   (wr_vpn),
    .match (wr_match),
    .any   (wr_any),
    .idx   (wr_match_idx)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .valid      (valid_q),
    .oldest_idx (oldest_idx),
    .victim_idx (victim_idx)
  );

  assign wr_idx = wr_any ? wr_match_idx : victim_idx;

  // Recency: a write takes precedence over a hit in the same cycle.
  logic             touch_en;
  logic [IDX_W-1:0] touch_idx;

  assign touch_en  = wr_en || lk_hit;
  assign touch_idx = wr_en ? wr_idx : lk_idx;

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .oldest_idx (oldest_idx)
  );

  // Next-state logic for the entries.
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    ppn_d   = ppn_q;
    if (wsrc == WSRC_FLUSH) begin
      valid_d = '0;
    end else if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      tag_d[wr_idx]   = wr_vpn;
      ppn_d[wr_idx]   = wr_ppn;
    end
  end

  assign store_en = wr_en || (wsrc == WSRC_FLUSH);
  assign prot_d   = !kw_kernel && (kw_en || kw_flush);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (store_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q <= tag_d;
      ppn_q <= ppn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_q <= 1'b0;
    else        prot_q <= prot_d;
  end

  assign prot_err = prot_q;

  // Checks kept beside the logic they guard.
  a_r13_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r2_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss) && ((lk_hit || lk_miss) == lk_req));

  a_r9_refused_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (!kw_kernel && (kw_en || kw_flush)) |=> prot_err);

  a_r9_flag_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (kw_kernel || !(kw_en || kw_flush)) |=> !prot_err);

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (kw_kernel && kw_flush) |=> (valid_q == '0));

  a_r4_fault_keeps_entries: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_valid && wk_fault && !kw_en && !kw_flush) |=> $stable(valid_q));

  a_r3_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wk_valid && !wk_fault && !kw_en && !kw_flush) |=> (valid_q != '0));
endmodule

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
  localparam int unsigned N     = 4;
  localparam int unsigned VA_W  = 32;
  localparam int unsigned PA_W  = 32;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PPN_W = PA_W - OFF_W;

  logic             clk;
  logic             rst_n;
  logic             lk_req;
  logic [VA_W-1:0]  lk_vaddr;
  logic             lk_hit, lk_miss, lk_fault, walk_req;
  logic [PA_W-1:0]  lk_paddr;
  logic [VPN_W-1:0] walk_vpn;
  logic             wk_valid, wk_fault;
  logic [VPN_W-1:0] wk_vpn;
  logic [PPN_W-1:0] wk_ppn;
  logic             kw_kernel, kw_en, kw_flush;
  logic [VPN_W-1:0] kw_vpn;
  logic [PPN_W-1:0] kw_ppn;
  logic             prot_err;

  int checks = 0;
  int errors = 0;

  xlat_tlb #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_paddr(lk_paddr), .lk_fault(lk_fault), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .wk_valid(wk_valid), .wk_fault(wk_fault), .wk_vpn(wk_vpn), .wk_ppn(wk_ppn),
    .kw_kernel(kw_kernel), .kw_en(kw_en), .kw_flush(kw_flush),
    .kw_vpn(kw_vpn), .kw_ppn(kw_ppn), .prot_err(prot_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_req = 0; lk_vaddr = '0; wk_valid = 0; wk_fault = 0; wk_vpn = '0; wk_ppn = '0;
    kw_kernel = 0; kw_en = 0; kw_flush = 0; kw_vpn = '0; kw_ppn = '0;
  endtask

  // Lookup held across one rising edge so that a hit counts as a use.
  task automatic look(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                      input bit exp_hit, input logic [PPN_W-1:0] exp_ppn, input string req);
    @(negedge clk);
    idle();
    lk_req = 1; lk_vaddr = {vpn, off};
    #1;
    chk(lk_hit == exp_hit, req, 64'(lk_hit), 64'(exp_hit));
    if (exp_hit) chk(lk_paddr == {exp_ppn, off}, req, 64'(lk_paddr), 64'({exp_ppn, off}));
    else begin
      chk(lk_miss && walk_req, req, 64'({lk_miss, walk_req}), 64'h3);
      chk(walk_vpn == vpn, req, 64'(walk_vpn), 64'(vpn));
    end
    @(negedge clk);
    idle();
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn);
    @(negedge clk);
    idle();
    wk_valid = 1; wk_vpn = vpn; wk_ppn = ppn;
    @(negedge clk);
    idle();
  endtask

  task automatic kwrite(input bit kern, input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn);
    @(negedge clk);
    idle();
    kw_kernel = kern; kw_en = 1; kw_vpn = vpn; kw_ppn = ppn;
    @(negedge clk);
    idle();
  endtask

  task automatic kflush(input bit kern);
    @(negedge clk);
    idle();
    kw_kernel = kern; kw_flush = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(prot_err == 0, "R12 prot_err", 64'(prot_err), 0);
    chk(!lk_hit && !lk_miss && !walk_req, "R2 idle outputs", 64'({lk_hit, lk_miss, walk_req}), 0);
    look(20'h00001, 12'h000, 0, '0, "R12 empty after reset");
  endtask

  task automatic t_fill_hit();
    look(20'h12345, 12'h678, 0, '0, "R2 miss request");
    fill(20'h12345, 20'hABCDE);
    look(20'h12345, 12'h678, 1, 20'hABCDE, "R3 fill then hit");
    look(20'h12345, 12'hFFF, 1, 20'hABCDE, "R1 offset passes through");
  endtask

  task automatic t_fault();
    @(negedge clk);
    idle();
    wk_valid = 1; wk_fault = 1; wk_vpn = 20'h0BEEF; wk_ppn = 20'h11111;
    #1;
    chk(lk_fault == 1, "R4 fault forwarded", 64'(lk_fault), 1);
    @(negedge clk);
    idle();
    #1;
    chk(lk_fault == 0, "R4 fault drops", 64'(lk_fault), 0);
    look(20'h0BEEF, 12'h0, 0, '0, "R4 fault writes nothing");
  endtask

  task automatic t_fill_all();
    kflush(1);
    for (int i = 0; i < N; i++) fill(VPN_W'(20'h100 + i), PPN_W'(20'h500 + i));
    for (int i = 0; i < N; i++) look(VPN_W'(20'h100 + i), 12'h10, 1, PPN_W'(20'h500 + i), "R5 no early eviction");
  endtask

  task automatic t_lru();
    kflush(1);
    for (int i = 0; i < N; i++) fill(VPN_W'(20'h200 + i), PPN_W'(20'h600 + i));
    look(20'h200, 12'h0, 1, 20'h600, "R6 touch oldest");
    fill(20'h2FF, 20'h6FF);
    look(20'h201, 12'h0, 0, '0, "R6 lru victim evicted");
    look(20'h200, 12'h0, 1, 20'h600, "R6 touched entry kept");
    look(20'h2FF, 12'h0, 1, 20'h6FF, "R6 new entry present");
    for (int i = 2; i < N; i++) look(VPN_W'(20'h200 + i), 12'h0, 1, PPN_W'(20'h600 + i), "R6 others kept");
  endtask

  task automatic t_kwrite();
    kwrite(1, 20'h200, 20'h7777);
    look(20'h200, 12'h4, 1, 20'h7777, "R8 kernel write");
    look(20'h2FF, 12'h0, 1, 20'h6FF, "R7 overwrite in place");
    fill(20'h2FF, 20'h6AA);
    for (int i = 2; i < N; i++) look(VPN_W'(20'h200 + i), 12'h0, 1, PPN_W'(20'h600 + i), "R7 refill no eviction");
    look(20'h2FF, 12'h0, 1, 20'h6AA, "R7 refill updates ppn");
  endtask

  task automatic t_prot();
    kwrite(0, 20'h200, 20'h1234);
    chk(prot_err == 1, "R9 user write flagged", 64'(prot_err), 1);
    look(20'h200, 12'h0, 1, 20'h7777, "R9 user write ignored");
    chk(prot_err == 0, "R9 flag one cycle", 64'(prot_err), 0);
    kflush(0);
    chk(prot_err == 1, "R9 user flush flagged", 64'(prot_err), 1);
    look(20'h2FF, 12'h0, 1, 20'h6AA, "R9 user flush ignored");
  endtask

  task automatic t_flush();
    kflush(1);
    chk(prot_err == 0, "R10 kernel flush not flagged", 64'(prot_err), 0);
    look(20'h200, 12'h0, 0, '0, "R10 flush clears");
    look(20'h2FF, 12'h0, 0, '0, "R10 flush clears all");
  endtask

  task automatic t_prio();
    @(negedge clk);
    idle();
    kw_kernel = 1; kw_en = 1; kw_vpn = 20'h300; kw_ppn = 20'h800;
    wk_valid = 1; wk_vpn = 20'h301; wk_ppn = 20'h801;
    @(negedge clk);
    idle();
    look(20'h300, 12'h0, 1, 20'h800, "R11 kernel write wins");
    look(20'h301, 12'h0, 0, '0, "R11 fill dropped");
    @(negedge clk);
    idle();
    kw_kernel = 1; kw_flush = 1; kw_en = 1; kw_vpn = 20'h302; kw_ppn = 20'h802;
    @(negedge clk);
    idle();
    look(20'h302, 12'h0, 0, '0, "R11 flush wins");
    look(20'h300, 12'h0, 0, '0, "R11 flush applied");
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_hit();
    t_fault();
    t_fill_all();
    t_lru();
    t_kwrite();
    t_prot();
    t_flush();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule